// File: doc/BRIEF.md
# Vector length configuration unit

This block holds the vector configuration state of a vector unit and updates it whenever a set-length request arrives. A request carries the application vector length the software asks for, a 3-bit register-grouping field (group multiplier) that also covers fractional groupings of 1/2, 1/4 and 1/8 of a register, a 3-bit element-width field, and the tail and mask policy bits. From these the unit works out the largest vector length the configuration allows, grants a vector length no larger than that, and stores the configuration word. A configuration that cannot be honoured raises an illegal flag instead.

The register width and the largest supported element width are elaboration parameters. A fractional grouping does not change how elements are executed. It only shortens the vector length that results, and it narrows the set of legal element widths. The request side uses a valid/ready handshake. Results are registered, show up on the cycle after a request is accepted, and stay in place until the next accepted request.

Top module: `vcfg_unit`

## Requirements
- R1: Group multiplier codes are 3'b111=8, 3'b110=4, 3'b101=2, 3'b100=1, 3'b011=1/2, 3'b010=1/4, 3'b001=1/8. Code 3'b000 is reserved and always yields an illegal configuration.
- R2: Element width codes are 3'b000=8, 3'b001=16, 3'b010=32, 3'b011=64 bits. Codes 3'b100 to 3'b111 yield an illegal configuration.
- R3: For a legal setting, res_vlmax = (VLEN / SEW) * LMUL, with fractional multipliers included. With VLEN=256, SEW=8 and LMUL=1/8 this gives 4.
- R4: A setting is illegal when SEW > ELEN. When LMUL < 1 it is also illegal when SEW > LMUL*ELEN.
- R5: For a legal setting, res_vl = min(req_avl, res_vlmax). A request length of 0 grants 0.
- R6: For an illegal setting, res_vill=1 and res_vl, res_vlmax, res_lmul, res_sew, res_ta and res_ma are all 0.
- R7: A request is accepted on a rising edge where req_valid and req_ready are both 1. Its results appear after that edge, together with a one-cycle res_valid pulse. When no request is accepted, the outputs hold and res_valid is 0.
- R8: During reset, req_ready=0, res_valid=0 and res_vill=1, and every other result is 0. From the first edge after reset is released, req_ready is 1.
- R9: For a legal setting, res_lmul, res_sew, res_ta and res_ma equal the fields of the accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Set-length request present |
| req_ready | output | 1 | Unit can accept a request |
| req_avl | input | AVL_W | Requested application vector length |
| req_lmul | input | 3 | Group multiplier code |
| req_sew | input | 3 | Element width code |
| req_ta | input | 1 | Tail policy bit to store |
| req_ma | input | 1 | Mask policy bit to store |
| res_valid | output | 1 | One-cycle pulse after an accepted request |
| res_vlmax | output | $clog2(VLEN)+1 | Largest vector length of the stored setting |
| res_vl | output | $clog2(VLEN)+1 | Granted vector length |
| res_lmul | output | 3 | Stored group multiplier code |
| res_sew | output | 3 | Stored element width code |
| res_ta | output | 1 | Stored tail policy bit |
| res_ma | output | 1 | Stored mask policy bit |
| res_vill | output | 1 | Illegal configuration flag |

## Verification
The assertions check the following on every cycle:
- the granted length never exceeds the maximum;
- an illegal flag always comes with cleared fields;
- every accepted request is answered on the next cycle, and nothing changes without one;
- a zero request length, a reserved multiplier, or too wide an element at a 1/8 grouping gives the expected result.

Only the bench's scenarios can show the following:
- the exact maximum for each multiplier and width pair, including the fractional ones;
- where the legality boundary falls at 1/2 and 1/4;
- that the policy bits are stored;
- the reset values.

The bench covers these by sweeping all 64 code pairs against an independent model.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

    typedef enum logic [2:0] {
        GRP_RSVD = 3'b000,
        GRP_F8   = 3'b001,
        GRP_F4   = 3'b010,
        GRP_F2   = 3'b011,
        GRP_X1   = 3'b100,
        GRP_X2   = 3'b101,
        GRP_X4   = 3'b110,
        GRP_X8   = 3'b111
    } grp_code_e;

    typedef enum logic [2:0] {
        EW_8  = 3'b000,
        EW_16 = 3'b001,
        EW_32 = 3'b010,
        EW_64 = 3'b011
    } ew_code_e;

    // log2 of the integer multiplier code used as unity
    localparam int GRP_UNITY = 4;
    // element width code 0 means 2^3 bits
    localparam int EW_LOG_BASE = 3;

endpackage

// File: rtl/vcfg_decode.sv
module vcfg_decode
    import vcfg_pkg::*;
#(
    parameter int ELEN = 64
) (
    input  logic [2:0] grp_code,
    input  logic [2:0] ew_code,
    output logic       legal,
    output logic [3:0] shamt
);
    localparam int ELEN_LOG = $clog2(ELEN);

    int ew_log;
    int ew_limit;

    always_comb begin
        ew_log = int'(ew_code) + EW_LOG_BASE;
        if (int'(grp_code) >= GRP_UNITY) begin
            ew_limit = ELEN_LOG;
        end else begin
            // fractional grouping narrows the widest legal element
            ew_limit = ELEN_LOG - (GRP_UNITY - int'(grp_code));
        end
        legal = (grp_code != GRP_RSVD) && (ew_code <= EW_64) && (ew_log <= ew_limit);
        // VLMAX = (VLEN*8) >> (ew_log + 7 - grp_code)
        if (legal) begin
            shamt = 4'(ew_log + 7 - int'(grp_code));
        end else begin
            shamt = 4'd0;
        end
    end

endmodule

// File: rtl/vcfg_limit.sv
module vcfg_limit #(
    parameter int VLEN  = 256,
    parameter int AVL_W = 32
) (
    input  logic                       legal,
    input  logic [3:0]                 shamt,
    input  logic [AVL_W-1:0]           avl,
    output logic [$clog2(VLEN):0]      vlmax,
    output logic [$clog2(VLEN):0]      vl
);
    localparam int VLMAX_W  = $clog2(VLEN) + 1;
    localparam int SCALED_W = VLMAX_W + 3;
    localparam int CMP_W    = (AVL_W > VLMAX_W) ? AVL_W : VLMAX_W;
    localparam logic [SCALED_W-1:0] SCALED = SCALED_W'(VLEN) << 3;

    logic [SCALED_W-1:0] full;
    logic [CMP_W-1:0]    avl_x;
    logic [CMP_W-1:0]    max_x;

    always_comb begin
        full  = SCALED >> shamt;
        vlmax = legal ? full[VLMAX_W-1:0] : '0;
        avl_x = CMP_W'(avl);
        max_x = CMP_W'(vlmax);
        if (!legal) begin
            vl = '0;
        end else if (avl_x < max_x) begin
            vl = avl_x[VLMAX_W-1:0];
        end else begin
            vl = vlmax;
        end
    end

endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit
    import vcfg_pkg::*;
#(
    parameter int VLEN  = 256,
    parameter int ELEN  = 64,
    parameter int AVL_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [AVL_W-1:0]        req_avl,
    input  logic [2:0]              req_lmul,
    input  logic [2:0]              req_sew,
    input  logic                    req_ta,
    input  logic                    req_ma,
    output logic                    res_valid,
    output logic [$clog2(VLEN):0]   res_vlmax,
    output logic [$clog2(VLEN):0]   res_vl,
    output logic [2:0]              res_lmul,
    output logic [2:0]              res_sew,
    output logic                    res_ta,
    output logic                    res_ma,
    output logic                    res_vill
);
    localparam int VLMAX_W = $clog2(VLEN) + 1;

    typedef struct packed {
        logic               ready;
        logic               valid;
        logic [VLMAX_W-1:0] vlmax;
        logic [VLMAX_W-1:0] vl;
        logic [2:0]         grp;
        logic [2:0]         ew;
        logic               ta;
        logic               ma;
        logic               ill;
    } cfg_state_t;

    localparam cfg_state_t RESET_STATE = '{
        ready: 1'b0, valid: 1'b0, vlmax: '0, vl: '0,
        grp: 3'b000, ew: 3'b000, ta: 1'b0, ma: 1'b0, ill: 1'b1
    };

    cfg_state_t state_d, state_q;
    logic               cfg_legal;
    logic [3:0]         cfg_shamt;
    logic [VLMAX_W-1:0] cand_vlmax;
    logic [VLMAX_W-1:0] cand_vl;
    logic               accept;

    vcfg_decode #(.ELEN(ELEN)) u_decode (
        .grp_code (req_lmul),
        .ew_code  (req_sew),
        .legal    (cfg_legal),
        .shamt    (cfg_shamt)
    );

    vcfg_limit #(.VLEN(VLEN), .AVL_W(AVL_W)) u_limit (
        .legal (cfg_legal),
        .shamt (cfg_shamt),
        .avl   (req_avl),
        .vlmax (cand_vlmax),
        .vl    (cand_vl)
    );

    assign accept = req_valid && state_q.ready;

    always_comb begin
        state_d       = state_q;
        state_d.ready = 1'b1;
        state_d.valid = 1'b0;
        if (accept) begin
            state_d.valid = 1'b1;
            if (cfg_legal) begin
                state_d.vlmax = cand_vlmax;
                state_d.vl    = cand_vl;
                state_d.grp   = req_lmul;
                state_d.ew    = req_sew;
                state_d.ta    = req_ta;
                state_d.ma    = req_ma;
                state_d.ill   = 1'b0;
            end else begin
                state_d.vlmax = '0;
                state_d.vl    = '0;
                state_d.grp   = 3'b000;
                state_d.ew    = 3'b000;
                state_d.ta    = 1'b0;
                state_d.ma    = 1'b0;
                state_d.ill   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RESET_STATE;
        end else begin
            state_q <= state_d;
        end
    end

    assign req_ready = state_q.ready;
    assign res_valid = state_q.valid;
    assign res_vlmax = state_q.vlmax;
    assign res_vl    = state_q.vl;
    assign res_lmul  = state_q.grp;
    assign res_sew   = state_q.ew;
    assign res_ta    = state_q.ta;
    assign res_ma    = state_q.ma;
    assign res_vill  = state_q.ill;

    p_vl_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_vl <= res_vlmax);

    p_avl_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_avl == '0) |=> (res_vl == '0));

    p_ill_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_vill |-> (res_vl == '0 && res_vlmax == '0 && res_lmul == 3'b000 &&
                      res_sew == 3'b000 && !res_ta && !res_ma));

    p_resp_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> res_valid);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> (!res_valid && $stable(res_vl) &&
                                       $stable(res_vlmax) && $stable(res_vill)));

    p_reserved_grp_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_lmul == 3'b000) |=> res_vill);

    p_eighth_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ELEN <= 64 && req_valid && req_ready && req_lmul == 3'b001 &&
         req_sew != 3'b000) |=> res_vill);

endmodule

// File: tb/sim_vcfg_unit.sv
`timescale 1ns/1ps
module sim_vcfg_unit;
    localparam int VLEN  = 256;
    localparam int ELEN  = 64;
    localparam int AVL_W = 32;
    localparam int VW    = $clog2(VLEN) + 1;

    typedef struct packed {
        logic [2:0]  grp;
        logic [2:0]  ew;
        logic [31:0] avl;
        logic [15:0] vlmax;
        logic [15:0] vl;
        logic        ill;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{3'b001, 3'b000, 32'd100,  16'd4,   16'd4,   1'b0},
        '{3'b111, 3'b000, 32'd3000, 16'd256, 16'd256, 1'b0},
        '{3'b100, 3'b011, 32'd3,    16'd4,   16'd3,   1'b0},
        '{3'b011, 3'b011, 32'd9,    16'd0,   16'd0,   1'b1},
        '{3'b011, 3'b010, 32'd7,    16'd4,   16'd4,   1'b0},
        '{3'b010, 3'b010, 32'd7,    16'd0,   16'd0,   1'b1},
        '{3'b001, 3'b001, 32'd7,    16'd0,   16'd0,   1'b1},
        '{3'b000, 3'b000, 32'd7,    16'd0,   16'd0,   1'b1},
        '{3'b100, 3'b100, 32'd7,    16'd0,   16'd0,   1'b1},
        '{3'b101, 3'b001, 32'd0,    16'd32,  16'd0,   1'b0},
        '{3'b110, 3'b010, 32'd31,   16'd32,  16'd31,  1'b0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [AVL_W-1:0] req_avl = '0;
    logic [2:0]       req_lmul = 3'b000;
    logic [2:0]       req_sew = 3'b000;
    logic             req_ta = 1'b0;
    logic             req_ma = 1'b0;
    logic             res_valid;
    logic [VW-1:0]    res_vlmax;
    logic [VW-1:0]    res_vl;
    logic [2:0]       res_lmul;
    logic [2:0]       res_sew;
    logic             res_ta;
    logic             res_ma;
    logic             res_vill;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    vcfg_unit #(.VLEN(VLEN), .ELEN(ELEN), .AVL_W(AVL_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_avl(req_avl),
        .req_lmul(req_lmul), .req_sew(req_sew), .req_ta(req_ta), .req_ma(req_ma),
        .res_valid(res_valid), .res_vlmax(res_vlmax), .res_vl(res_vl),
        .res_lmul(res_lmul), .res_sew(res_sew), .res_ta(res_ta), .res_ma(res_ma),
        .res_vill(res_vill)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // independent model: vlmax = VLEN*num / (sew*den)
    task automatic model(input int grp, input int ew, input longint avl,
                         output int vlmax, output int vl, output bit ill);
        int sewb, num, den;
        ill = 1'b0;
        vlmax = 0;
        vl = 0;
        if (grp == 0 || ew > 3) begin
            ill = 1'b1;
        end else begin
            sewb = 8 << ew;
            if (grp >= 4) begin num = 1 << (grp - 4); den = 1; end
            else begin num = 1; den = 1 << (4 - grp); end
            if (sewb > ELEN || sewb * den > ELEN * num) ill = 1'b1;
            else begin
                vlmax = (VLEN * num) / (sewb * den);
                vl = (avl < vlmax) ? int'(avl) : vlmax;
            end
        end
    endtask

    task automatic issue(input logic [2:0] g, input logic [2:0] e,
                         input logic [31:0] a, input logic ta, input logic ma);
        @(negedge clk);
        req_lmul  = g;
        req_sew   = e;
        req_avl   = a;
        req_ta    = ta;
        req_ma    = ma;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        int mv, ml;
        bit mi;
        repeat (3) @(negedge clk);
        // R8 reset values
        check("R8 ready in reset", req_ready, 0);
        check("R8 valid in reset", res_valid, 0);
        check("R8 vill in reset", res_vill, 1);
        check("R8 vl in reset", res_vl, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 ready after reset", req_ready, 1);

        // table of vectors: R1 R2 R3 R4 R5 R6
        for (int i = 0; i < NVEC; i++) begin
            issue(VECS[i].grp, VECS[i].ew, VECS[i].avl, 1'b1, 1'b0);
            check("R7 valid pulse", res_valid, 1);
            check("R3 vlmax table", res_vlmax, VECS[i].vlmax);
            check("R5 vl table", res_vl, VECS[i].vl);
            check("R1 R2 R4 vill table", res_vill, VECS[i].ill);
        end

        // sweep all code pairs against the model
        for (int g = 0; g < 8; g++) begin
            for (int e = 0; e < 8; e++) begin
                logic [31:0] a;
                a = 32'((g * 37 + e * 11) % 300);
                issue(3'(g), 3'(e), a, 1'(e & 1), 1'(g & 1));
                model(g, e, a, mv, ml, mi);
                check("R4 vill sweep", res_vill, mi);
                check("R3 vlmax sweep", res_vlmax, mv);
                check("R5 vl sweep", res_vl, ml);
                if (mi) begin
                    check("R6 fields cleared", {res_lmul, res_sew, res_ta, res_ma}, 0);
                end else begin
                    check("R9 stored fields", {res_lmul, res_sew, res_ta, res_ma},
                          {3'(g), 3'(e), 1'(e & 1), 1'(g & 1)});
                end
            end
        end

        // R7 hold: change inputs without valid
        issue(3'b110, 3'b000, 32'd1000, 1'b1, 1'b1);
        check("R5 vl clamps", res_vl, 128);
        @(negedge clk);
        req_lmul = 3'b000;
        req_avl  = 32'd1;
        @(negedge clk);
        check("R7 no pulse when idle", res_valid, 0);
        check("R7 vl held", res_vl, 128);
        check("R7 vill held", res_vill, 0);

        // R5 zero request length at maximum grouping
        issue(3'b111, 3'b011, 32'd0, 1'b0, 1'b0);
        check("R5 zero avl", res_vl, 0);
        check("R3 vlmax x8 64b", res_vlmax, 32);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule